// File: doc/BRIEF.md
# Flash Erase and Program Sequencer

This block models the command side of an embedded nonvolatile memory controller. Software writes a control word to select a page erase, a whole-array erase or double-word programming, and then either sets a start bit or streams two 32-bit data words. The array itself is modelled as an internal register file in which an erased word reads as all ones. A cycle counter of configurable length stands in for the time the array needs to complete each operation.

A status word carries a completion flag and four error flags, all write-1-to-clear. The sequencer enforces an ordered protocol:

- An operation cannot begin while an earlier error is still unacknowledged.
- A double word may only be written over erased cells, unless the new value is all zeros.
- The two halves of a double word must arrive in order, low word first, at an even word address.

Top module: `flash_seq`

## Requirements
- R1: After reset, busy is 0, the status word is 0, the control readback is 0 and every array word reads 32'hFFFF_FFFF.
- R2: A control write with bit 0 (page erase) and bit 3 (start) set and a page number in bits [15:8] below the page count starts a page erase. When it completes, every word of that page reads all ones and all other words are unchanged.
- R3: A control write with bit 1 (whole-array erase) and bit 3 set erases every word. The whole-array erase takes priority when bit 0 is set in the same write.
- R4: Busy rises on the clock edge that accepts a launching write and stays high for exactly OP_CYCLES cycles. While busy, control writes and data writes have no effect.
- R5: Status bit 0 (done) is set on the edge where a successful operation completes and busy falls. It clears only when written with 1 on the clear port, and a set in the same cycle wins over a clear.
- R6: With bit 2 (program enable) set, a data write to an even word address followed by a data write to the next address launches programming. After busy falls, the even address holds the first word and the odd address holds the second.
- R7: Programming a double word that is not all ones with nonzero data sets status bit 1 (program error) instead of done, and leaves the array unchanged. All-zero data is always written.
- R8: A start, or a first data word, that arrives while any of status bits 1 to 4 is set sets status bit 2 (sequence error) and runs nothing.
- R9: A first data word at an odd address, or a second data word at any address other than the first plus one, sets status bit 3 (alignment error) and discards the pending word.
- R10: A page erase request with a page number at or above the page count sets status bit 4 (range error) and erases nothing.
- R11: Error flags clear only by writing 1 to them on the clear port. The control readback keeps the enable bits and the page number until the next accepted control write. The start bit always reads 0.
- R12: Data writes while program enable is 0 change neither the array nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word: [0] page erase, [1] array erase, [2] program, [3] start, [15:8] page |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 5 | Write-1-to-clear mask for the status bits |
| mem_we | input | 1 | Data word write strobe for programming |
| mem_addr | input | $clog2(WORDS) | Word address of the data write |
| mem_wdata | input | 32 | Data word to program |
| rd_addr | input | $clog2(WORDS) | Array read word address |
| rd_data | output | 32 | Array read data (combinational) |
| ctl_q | output | 16 | Control readback, same layout as ctl_wdata |
| busy | output | 1 | Operation in progress |
| status | output | 5 | [0] done, [1] program error, [2] sequence error, [3] alignment error, [4] range error |

## Verification
The bench covers several corner cases, and names the failure each one would expose:

- Overwriting a programmed double word with nonzero data, then with zeros. A design that skips the erased check would silently corrupt data; one that rejects zeros would block the legitimate clear-to-zero case.
- Launching while an error is pending. A design missing the sequence gate would keep running operations after an unacknowledged fault.
- Odd first addresses and non-adjacent second words. Mishandling either leaves a stale half pending, so a later write programs the wrong pair.
- An out-of-range page, a whole-array erase with the page bit also set, and writes issued during busy. Errors here would show as erased neighbours, a lost erase, or a corrupted readback.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
   localparam int CTL_W       = 16;
   localparam int CB_PAGE_ER  = 0;
   localparam int CB_ALL_ER   = 1;
   localparam int CB_PROG     = 2;
   localparam int CB_START    = 3;
   localparam int CB_PAGE_LSB = 8;
   localparam int PAGE_FW     = 8;

   localparam int ST_W         = 5;
   localparam int ST_DONE      = 0;
   localparam int ST_PROG_ERR  = 1;
   localparam int ST_SEQ_ERR   = 2;
   localparam int ST_ALIGN_ERR = 3;
   localparam int ST_RANGE_ERR = 4;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_PAGE,
      OP_ALL,
      OP_PROG
   } op_e;
endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
   parameter int OP_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   output logic busy,
   output logic done
);
   if (OP_CYCLES < 1) begin : g_bad_cycles
      $error("flash_seq_timer: OP_CYCLES must be at least 1");
   end

   if (OP_CYCLES == 1) begin : g_single
      logic busy_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy_q <= 1'b0;
         else        busy_q <= !busy_q && launch;
      end
      assign busy = busy_q;
      assign done = busy_q;
   end else begin : g_count
      localparam int CW = $clog2(OP_CYCLES);
      logic          busy_q;
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
         end else if (launch) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(OP_CYCLES - 1);
         end
      end
      assign busy = busy_q;
      assign done = busy_q && (cnt_q == '0);
   end
endmodule

// File: rtl/flash_seq_array.sv
module flash_seq_array #(
   parameter  int WORDS      = 64,
   parameter  int PAGE_WORDS = 16,
   localparam int AW         = $clog2(WORDS),
   localparam int DW_W       = AW - 1,
   localparam int NPAGES     = WORDS / PAGE_WORDS,
   localparam int PIDX_W     = (NPAGES > 1) ? $clog2(NPAGES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase_all,
   input  logic              erase_page,
   input  logic [PIDX_W-1:0] page_sel,
   input  logic              dw_we,
   input  logic [DW_W-1:0]   dw_idx,
   input  logic [63:0]       dw_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [31:0]       rd_data,
   output logic [63:0]       old_dw
);
   if (WORDS < 4 || (1 << AW) != WORDS) begin : g_bad_words
      $error("flash_seq_array: WORDS must be a power of two of at least 4");
   end
   if (PAGE_WORDS < 2 || (WORDS % PAGE_WORDS) != 0 || (PAGE_WORDS % 2) != 0) begin : g_bad_page
      $error("flash_seq_array: PAGE_WORDS must be even and divide WORDS");
   end

   logic [31:0] words [WORDS];

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam int PG = w / PAGE_WORDS;
      localparam int HI = w % 2;
      logic [31:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cell_q <= '1;
         end else if (erase_all || (erase_page && page_sel == PIDX_W'(PG))) begin
            cell_q <= '1;
         end else if (dw_we && dw_idx == DW_W'(w / 2)) begin
            cell_q <= (HI == 1) ? dw_data[63:32] : dw_data[31:0];
         end
      end
      assign words[w] = cell_q;
   end

   assign rd_data = words[rd_addr];
   assign old_dw  = {words[{dw_idx, 1'b1}], words[{dw_idx, 1'b0}]};
endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker #(
   parameter int OP_CYCLES = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic [4:0]  status,
   input logic [15:0] ctl_q,
   input logic        sts_clr_we
);
   logic [31:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_q <= '0;
      else if (busy) run_q <= run_q + 1'b1;
      else           run_q <= '0;
   end

   a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> run_q == 32'(OP_CYCLES));

   a_r4_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(ctl_q));

   a_r5_done_with_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[0]) |-> $fell(busy));

   a_r7_no_done_on_prog_err: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[1]) |-> !$rose(status[0]));

   a_r11_sticky_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_clr_we |=> ((status & $past(status)) == $past(status)));

   a_r11_start_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q[3]);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
   import flash_seq_pkg::*;
#(
   parameter int WORDS      = 64,
   parameter int PAGE_WORDS = 16,
   parameter int OP_CYCLES  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ctl_we,
   input  logic [15:0]              ctl_wdata,
   input  logic                     sts_clr_we,
   input  logic [4:0]               sts_clr_mask,
   input  logic                     mem_we,
   input  logic [$clog2(WORDS)-1:0] mem_addr,
   input  logic [31:0]              mem_wdata,
   input  logic [$clog2(WORDS)-1:0] rd_addr,
   output logic [31:0]              rd_data,
   output logic [15:0]              ctl_q,
   output logic                     busy,
   output logic [4:0]               status
);
   localparam int AW     = $clog2(WORDS);
   localparam int DW_W   = AW - 1;
   localparam int NPAGES = WORDS / PAGE_WORDS;
   localparam int PIDX_W = (NPAGES > 1) ? $clog2(NPAGES) : 1;

   if (NPAGES > 255) begin : g_bad_pages
      $error("flash_seq: page count must fit the 8-bit page field");
   end

   logic               pe_q, ae_q, pg_q;
   logic [PAGE_FW-1:0] page_q;
   logic [ST_W-1:0]    flags_q, flag_set, flag_clr;
   op_e                op_q, launch_op;
   logic               launch, done;
   logic               phase_q;
   logic [AW-1:0]      first_addr_q;
   logic [31:0]        first_data_q;
   logic [DW_W-1:0]    dw_idx_q;
   logic [63:0]        dw_data_q;
   logic [63:0]        old_dw;
   logic               ctl_ok, start_req, err_pending, data_ok, second_ok, prog_ok;
   logic [PAGE_FW-1:0] wpage;
   logic               unused_ctl;

   assign unused_ctl  = ^ctl_wdata[7:4];
   assign wpage       = ctl_wdata[CB_PAGE_LSB +: PAGE_FW];
   assign ctl_ok      = ctl_we && !busy;
   assign start_req   = ctl_ok && ctl_wdata[CB_START] &&
                        (ctl_wdata[CB_PAGE_ER] || ctl_wdata[CB_ALL_ER]);
   assign err_pending = |flags_q[ST_RANGE_ERR:ST_PROG_ERR];
   assign data_ok     = mem_we && !ctl_we && !busy && pg_q;
   assign second_ok   = (mem_addr == first_addr_q + AW'(1));
   assign prog_ok     = (old_dw == '1) || (dw_data_q == '0);
   assign flag_clr    = sts_clr_we ? sts_clr_mask : '0;

   always_comb begin
      flag_set  = '0;
      launch    = 1'b0;
      launch_op = OP_NONE;
      if (start_req) begin
         if (err_pending) begin
            flag_set[ST_SEQ_ERR] = 1'b1;
         end else if (ctl_wdata[CB_ALL_ER]) begin
            launch    = 1'b1;
            launch_op = OP_ALL;
         end else if ({1'b0, wpage} >= 9'(NPAGES)) begin
            flag_set[ST_RANGE_ERR] = 1'b1;
         end else begin
            launch    = 1'b1;
            launch_op = OP_PAGE;
         end
      end
      if (data_ok) begin
         if (!phase_q) begin
            if (mem_addr[0])      flag_set[ST_ALIGN_ERR] = 1'b1;
            else if (err_pending) flag_set[ST_SEQ_ERR]   = 1'b1;
         end else if (second_ok) begin
            launch    = 1'b1;
            launch_op = OP_PROG;
         end else begin
            flag_set[ST_ALIGN_ERR] = 1'b1;
         end
      end
      if (done) begin
         if (op_q == OP_PROG && !prog_ok) flag_set[ST_PROG_ERR] = 1'b1;
         else                             flag_set[ST_DONE]     = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pe_q         <= 1'b0;
         ae_q         <= 1'b0;
         pg_q         <= 1'b0;
         page_q       <= '0;
         flags_q      <= '0;
         op_q         <= OP_NONE;
         phase_q      <= 1'b0;
         first_addr_q <= '0;
         first_data_q <= '0;
         dw_idx_q     <= '0;
         dw_data_q    <= '0;
      end else begin
         flags_q <= (flags_q & ~flag_clr) | flag_set;
         if (launch) op_q <= launch_op;
         if (ctl_ok) begin
            pe_q   <= ctl_wdata[CB_PAGE_ER];
            ae_q   <= ctl_wdata[CB_ALL_ER];
            pg_q   <= ctl_wdata[CB_PROG];
            page_q <= wpage;
            if (!ctl_wdata[CB_PROG]) phase_q <= 1'b0;
         end
         if (data_ok) begin
            if (!phase_q) begin
               if (!mem_addr[0] && !err_pending) begin
                  phase_q      <= 1'b1;
                  first_addr_q <= mem_addr;
                  first_data_q <= mem_wdata;
               end
            end else begin
               phase_q <= 1'b0;
               if (second_ok) begin
                  dw_idx_q  <= first_addr_q[AW-1:1];
                  dw_data_q <= {mem_wdata, first_data_q};
               end
            end
         end
      end
   end

   flash_seq_timer #(.OP_CYCLES(OP_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .busy   (busy),
      .done   (done)
   );

   flash_seq_array #(.WORDS(WORDS), .PAGE_WORDS(PAGE_WORDS)) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .erase_all  (done && op_q == OP_ALL),
      .erase_page (done && op_q == OP_PAGE),
      .page_sel   (page_q[PIDX_W-1:0]),
      .dw_we      (done && op_q == OP_PROG && prog_ok),
      .dw_idx     (dw_idx_q),
      .dw_data    (dw_data_q),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .old_dw     (old_dw)
   );

   assign ctl_q  = {page_q, 4'b0000, 1'b0, pg_q, ae_q, pe_q};
   assign status = flags_q;
endmodule

bind flash_seq flash_seq_checker #(.OP_CYCLES(OP_CYCLES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .status     (status),
   .ctl_q      (ctl_q),
   .sts_clr_we (sts_clr_we)
);

// File: tb/flash_seq_bench.sv
module flash_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WORDS      = 64;
   localparam int PAGE_WORDS = 16;
   localparam int OPC        = 8;
   localparam int NP         = WORDS / PAGE_WORDS;
   localparam int AW         = $clog2(WORDS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_we = 1'b0;
   logic [15:0]   ctl_wdata = '0;
   logic          sts_clr_we = 1'b0;
   logic [4:0]    sts_clr_mask = '0;
   logic          mem_we = 1'b0;
   logic [AW-1:0] mem_addr = '0;
   logic [31:0]   mem_wdata = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0]   rd_data;
   logic [15:0]   ctl_q;
   logic          busy;
   logic [4:0]    status;

   int nchk = 0;
   int nerr = 0;
   bit done_rep = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   flash_seq #(.WORDS(WORDS), .PAGE_WORDS(PAGE_WORDS), .OP_CYCLES(OPC)) u_flash_seq (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .sts_clr_we(sts_clr_we), .sts_clr_mask(sts_clr_mask), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_addr(rd_addr),
      .rd_data(rd_data), .ctl_q(ctl_q), .busy(busy), .status(status)
   );

   // reference model state
   logic [31:0] m_mem [WORDS];
   logic [4:0]  m_flags, ms, mc;
   bit          m_busy, m_pe, m_ae, m_pg, m_phase, errp;
   int          m_cnt, m_op, m_fa, m_dw;
   logic [7:0]  m_page;
   logic [31:0] m_fd;
   logic [63:0] m_dwd, old;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) m_mem[i] = '1;
         m_flags = '0; m_busy = 0; m_pe = 0; m_ae = 0; m_pg = 0; m_phase = 0;
         m_cnt = 0; m_op = 0; m_page = '0; m_fa = 0; m_fd = '0; m_dw = 0; m_dwd = '0;
      end else begin
         ms = '0;
         mc = sts_clr_we ? sts_clr_mask : 5'b0;
         errp = |m_flags[4:1];
         if (m_busy) begin
            m_cnt--;
            if (m_cnt == 0) begin
               m_busy = 0;
               if (m_op == 2) begin
                  old = {m_mem[2*m_dw+1], m_mem[2*m_dw]};
                  if (old != '1 && m_dwd != '0) ms[1] = 1'b1;
                  else begin
                     m_mem[2*m_dw] = m_dwd[31:0];
                     m_mem[2*m_dw+1] = m_dwd[63:32];
                     ms[0] = 1'b1;
                  end
               end else if (m_op == 1) begin
                  for (int i = 0; i < WORDS; i++) m_mem[i] = '1;
                  ms[0] = 1'b1;
               end else begin
                  for (int i = 0; i < PAGE_WORDS; i++) m_mem[int'(m_page)*PAGE_WORDS+i] = '1;
                  ms[0] = 1'b1;
               end
            end
         end else if (ctl_we) begin
            m_pe = ctl_wdata[0]; m_ae = ctl_wdata[1]; m_pg = ctl_wdata[2];
            m_page = ctl_wdata[15:8];
            if (!m_pg) m_phase = 0;
            if (ctl_wdata[3] && (m_pe || m_ae)) begin
               if (errp) ms[2] = 1'b1;
               else if (m_ae) begin m_busy = 1; m_cnt = OPC; m_op = 1; end
               else if (int'(m_page) >= NP) ms[4] = 1'b1;
               else begin m_busy = 1; m_cnt = OPC; m_op = 0; end
            end
         end else if (mem_we && m_pg) begin
            if (!m_phase) begin
               if (mem_addr[0]) ms[3] = 1'b1;
               else if (errp) ms[2] = 1'b1;
               else begin m_phase = 1; m_fa = int'(mem_addr); m_fd = mem_wdata; end
            end else begin
               m_phase = 0;
               if (int'(mem_addr) == m_fa + 1) begin
                  m_busy = 1; m_cnt = OPC; m_op = 2; m_dw = m_fa / 2;
                  m_dwd = {mem_wdata, m_fd};
               end else ms[3] = 1'b1;
            end
         end
         m_flags = (m_flags & ~mc) | ms;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // compare against the model on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R4 busy vs model", 64'(busy), 64'(m_busy));
         chk("R5 status vs model", 64'(status), 64'(m_flags));
         chk("R11 ctl_q vs model", 64'(ctl_q), 64'({m_page, 4'b0, 1'b0, m_pg, m_ae, m_pe}));
      end
   end

   task automatic ctl(input logic [15:0] v);
      @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_we = 1'b0;
   endtask

   task automatic clr(input logic [4:0] m);
      @(negedge clk); sts_clr_we = 1'b1; sts_clr_mask = m;
      @(negedge clk); sts_clr_we = 1'b0;
   endtask

   task automatic memw(input int a, input logic [31:0] d);
      @(negedge clk); mem_we = 1'b1; mem_addr = AW'(a); mem_wdata = d;
      @(negedge clk); mem_we = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 100 && busy; i++) @(negedge clk);
   endtask

   task automatic rd(input string tag, input int a, input logic [31:0] exp);
      @(negedge clk); rd_addr = AW'(a); #1;
      chk(tag, 64'(rd_data), 64'(exp));
   endtask

   task automatic sweep(input string tag);
      for (int i = 0; i < WORDS; i++) begin
         rd_addr = AW'(i); #1;
         chk(tag, 64'(rd_data), 64'(m_mem[i]));
      end
   endtask

   task automatic report();
      if (!done_rep) begin
         done_rep = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      nerr++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 busy", 64'(busy), 64'd0);
      chk("R1 status", 64'(status), 64'd0);
      chk("R1 ctl_q", 64'(ctl_q), 64'd0);
      rd("R1 erased word", 37, 32'hFFFF_FFFF);
      sweep("R1 array");

      // R6: program a double word at 0
      ctl(16'h0004);
      memw(0, 32'h1234_5678);
      memw(1, 32'h9ABC_DEF0);
      chk("R4 busy after launch", 64'(busy), 64'd1);
      memw(6, 32'h0);                      // ignored while busy
      ctl(16'h0003 | 16'h0008);            // ignored while busy
      wait_idle();
      rd("R6 low word", 0, 32'h1234_5678);
      rd("R6 high word", 1, 32'h9ABC_DEF0);
      chk("R5 done set", 64'(status), 64'h01);
      chk("R4 ctl unchanged by busy write", 64'(ctl_q), 64'h0004);
      rd("R4 busy data write ignored", 6, 32'hFFFF_FFFF);
      clr(5'b00001);
      chk("R5 done cleared", 64'(status), 64'h00);

      // R7: overwrite non-erased with nonzero data
      memw(0, 32'h1);
      memw(1, 32'h2);
      wait_idle();
      chk("R7 prog err", 64'(status), 64'h02);
      rd("R7 unchanged", 0, 32'h1234_5678);

      // R8: first word while error pending
      memw(2, 32'hAAAA_AAAA);
      chk("R8 seq err", 64'(status), 64'h06);
      ctl(16'h010D);                       // page erase start, error pending
      chk("R8 no busy", 64'(busy), 64'd0);
      clr(5'b00100);
      chk("R11 only seq cleared", 64'(status), 64'h02);
      clr(5'b11110);
      chk("R11 all cleared", 64'(status), 64'h00);

      // R7: all-zero data may overwrite
      ctl(16'h0004);
      memw(0, 32'h0);
      memw(1, 32'h0);
      wait_idle();
      rd("R7 zero written", 1, 32'h0);
      chk("R7 zero done", 64'(status), 64'h01);
      clr(5'b00001);

      // R9: odd first, then non-adjacent second
      memw(3, 32'h5);
      chk("R9 odd first", 64'(status), 64'h08);
      clr(5'b01000);
      memw(4, 32'h5);
      memw(7, 32'h6);
      chk("R9 non-adjacent", 64'(status), 64'h08);
      chk("R9 no launch", 64'(busy), 64'd0);
      clr(5'b01000);
      memw(5, 32'h7);                      // stale half must not pair with this
      chk("R9 pending discarded", 64'(status), 64'h08);
      clr(5'b01000);

      // R12: data writes with program disabled
      ctl(16'h0000);
      memw(8, 32'h0);
      memw(9, 32'h0);
      repeat (OPC + 2) @(negedge clk);
      chk("R12 status unchanged", 64'(status), 64'h00);
      rd("R12 array unchanged", 8, 32'hFFFF_FFFF);

      // R2: page erase of page 0 leaves page 1 intact
      ctl(16'h0004);
      memw(16, 32'hCAFE_0001);
      memw(17, 32'hCAFE_0002);
      wait_idle();
      clr(5'b00001);
      ctl(16'h0009);
      chk("R11 start reads 0, enable kept", 64'(ctl_q), 64'h0001);
      wait_idle();
      rd("R2 page 0 erased", 0, 32'hFFFF_FFFF);
      rd("R2 page 1 kept", 16, 32'hCAFE_0001);
      sweep("R2 array");
      clr(5'b00001);

      // R10: out-of-range page
      ctl(16'h0509);
      chk("R10 range err", 64'(status), 64'h10);
      chk("R10 no busy", 64'(busy), 64'd0);
      clr(5'b10000);

      // R3: whole-array erase wins over page erase
      ctl(16'h010B);
      wait_idle();
      rd("R3 page 1 erased", 17, 32'hFFFF_FFFF);
      chk("R3 done", 64'(status), 64'h01);
      sweep("R3 array");

      // R5: set wins over clear in the same cycle
      clr(5'b00001);
      ctl(16'h0004);
      memw(20, 32'h11);
      @(negedge clk); mem_we = 1'b1; mem_addr = AW'(21); mem_wdata = 32'h22;
      @(negedge clk); mem_we = 1'b0;
      repeat (OPC - 1) @(negedge clk);
      sts_clr_we = 1'b1; sts_clr_mask = 5'b00001;   // same edge busy falls
      @(negedge clk); sts_clr_we = 1'b0;
      chk("R5 set wins", 64'(status), 64'h01);
      rd("R6 second pair", 21, 32'h22);

      repeat (3) @(negedge clk);
      report();
   end
endmodule